// File: doc/BRIEF.md
# Half-Band Rate-Conversion Filter

This block is a linear-phase low-pass FIR with fixed, symmetric half-band coefficients. It can double a stream's sample rate, halve it, or filter it at the same rate. Its single clock runs at the faster of the input and output rates. In interpolation the filter sees a zero in place of every second sample. In decimation the output register is loaded only on every second clock. A sync input pins down which edges are the sample edges, so the host always knows the phase.

The 12-bit signed input feeds a 39-entry tap line. Only the centre tap and the taps at odd distances from it are nonzero, and symmetric pairs are added before they are multiplied. The full-precision sum, in units of 2^-16 of an input LSB, goes to a register that a rounding stage further down the chip consumes. A pass-through mode delays the input by the same 34 clocks as the filter's group delay, so a change of mode keeps streams time-aligned with one another.

Top module: `hb_filter`

## Requirements
- R1: While `rst` is high, `dout` reads 0 from the first clock edge inside reset onward.
- R2: In equal-rate mode (`modeSel` = 2'b10), a sample captured at edge k gives the output sequence x·c[j] after edge k+15+j, for j = 0..38. c[19] = 32768. c[19±d] is 0 for even d ≠ 0. For odd d = 1,3,...,19 it is 20754, -6600, 3600, -2250, 1450, -900, 540, -300, 150, -60. `dout` is the linear sum of such responses, with the peak after edge k+34.
- R3: In equal-rate mode, a constant input x settles to `dout` = x·65536 (unity DC gain).
- R4: In pass-through mode (`modeSel` = 2'b11), `dout` after edge k+34 equals the sample captured at edge k multiplied by 65536, on every clock.
- R5: In interpolate mode (`modeSel` = 2'b00), `syncIn` high at edge 0 and low at edge 1 makes edges 1, 3, 5, … take `din`. A zero enters the filter on the other edges, and `din` there has no effect. Driving `syncIn` high on every even edge gives the same result. After reset with no sync pulse, the first edge inserts a zero.
- R6: With interpolate mode and `halfGain` = 0, the filtered result is doubled, so a constant input x gives `dout` = x·65536 on every clock.
- R7: With interpolate mode and `halfGain` = 1, the filtered result is not doubled, so a constant input x gives `dout` = x·32768.
- R8: In decimate mode (`modeSel` = 2'b01), `dout` is loaded only on edge 0 and the even edges after a sync pulse, and holds on the odd edges. A square-wave sync that is high on even edges is equivalent. After reset with no sync, the first edge loads.
- R9: In equal-rate and pass-through modes, `syncIn` has no effect on `dout`.
- R10: `modeSel` and `halfGain` are captured only while `rst` is high. Later changes have no effect until the next reset.
- R11: In decimate mode, each loaded value is the equal-rate filter result for that edge, so a constant input x gives x·65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the faster of the input and output sample rates |
| rst | input | 1 | Synchronous active-high reset; also latches mode and gain |
| modeSel | input | 2 | 00 interpolate, 01 decimate, 10 equal-rate, 11 pass-through |
| halfGain | input | 1 | Interpolate only: 1 selects -6 dB, 0 selects unity |
| syncIn | input | 1 | Phase marker for interpolate and decimate |
| din | input | IN_W (12) | Signed input sample |
| dout | output | IN_W+19 (31) | Signed full-precision result, 16 fractional bits |

## Verification
A single impulse in equal-rate mode exposes each coefficient on its own clock, which separates a wrong tap value, a wrong tap position and a wrong start delay. Steps and long constant runs in every filtering mode check the DC gain, the 0 dB doubling against the -6 dB path, and the sum of the polyphase halves. In interpolate runs the even-edge samples are deliberately different, so any leak of an even-edge sample is visible. Random data with random sync in equal-rate and pass-through runs, a mode change made after reset, and full-scale alternating data cover sync immunity, mode latching, and the width of the accumulation.

// File: rtl/hb_filter_pkg.sv
package hb_filter_pkg;

  localparam int FRAC_W = 16;
  localparam int CENTRE_TAP = 32768;

  typedef enum logic [1:0] {
    MODE_INTERP = 2'd0,
    MODE_DECIM  = 2'd1,
    MODE_EQUAL  = 2'd2,
    MODE_BYPASS = 2'd3
  } hb_mode_e;

  typedef struct packed {
    logic feedSample;
    logic loadOut;
    logic gainDouble;
    logic passThru;
  } hb_strobe_t;

  // Side tap value at an odd distance from the centre, Q16; sum of all = 0.25
  function automatic int sideTap(input int offset);
    case (offset)
      1:       return 20754;
      3:       return -6600;
      5:       return 3600;
      7:       return -2250;
      9:       return 1450;
      11:      return -900;
      13:      return 540;
      15:      return -300;
      17:      return 150;
      19:      return -60;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/hb_filter_ctrl.sv
module hb_filter_ctrl
  import hb_filter_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] modeSel,
  input  logic       halfGain,
  input  logic       syncIn,
  output hb_mode_e   modeReg,
  output hb_strobe_t strb
);

  logic acceptNext;
  logic halfGainReg;

  // Mode and gain latch only during reset; phase flips every clock, sync forces it
  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg     <= hb_mode_e'(modeSel);
      halfGainReg <= halfGain;
      acceptNext  <= 1'b0;
    end else begin
      acceptNext  <= syncIn | ~acceptNext;
    end
  end

  always_comb begin
    strb.feedSample = (modeReg == MODE_INTERP) ? (acceptNext & ~syncIn) : 1'b1;
    strb.loadOut    = (modeReg == MODE_DECIM) ? (syncIn | ~acceptNext) : 1'b1;
    strb.gainDouble = (modeReg == MODE_INTERP) & ~halfGainReg;
    strb.passThru   = (modeReg == MODE_BYPASS);
  end

endmodule

// File: rtl/hb_filter_dp.sv
module hb_filter_dp
  import hb_filter_pkg::*;
#(
  parameter int IN_W        = 12,
  parameter int TAPS        = 39,
  parameter int START_DELAY = 15,
  parameter int OUT_W       = IN_W + FRAC_W + 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [IN_W-1:0]  din,
  input  hb_strobe_t              strb,
  output logic signed [OUT_W-1:0] dout
);

  localparam int HALF  = (TAPS - 1) / 2;
  localparam int FIRST = START_DELAY - 1;
  localparam int CTR   = FIRST + HALF;
  localparam int DEPTH = FIRST + TAPS;
  localparam int NPAIR = (HALF + 1) / 2;

  logic signed [IN_W-1:0]  line [DEPTH];
  logic signed [OUT_W-1:0] pairProd [NPAIR];
  logic signed [OUT_W-1:0] accSum;
  logic signed [OUT_W-1:0] passVal;
  logic signed [OUT_W-1:0] nextOut;

  // Lead-in delay and tap line share one shift register
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) line[i] <= '0;
    end else begin
      line[0] <= strb.feedSample ? din : '0;
      for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
    end
  end

  // Only odd distances carry weight: pre-add the mirror pair, then multiply once
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int OFF = 2 * p + 1;
    localparam logic signed [OUT_W-1:0] COEF = OUT_W'(sideTap(OFF));
    logic signed [IN_W:0] pairSum;
    assign pairSum     = (IN_W+1)'(line[CTR-OFF]) + (IN_W+1)'(line[CTR+OFF]);
    assign pairProd[p] = OUT_W'(pairSum) * COEF;
  end

  always_comb begin
    accSum = OUT_W'(line[CTR]) <<< (FRAC_W - 1);
    for (int p = 0; p < NPAIR; p++) accSum += pairProd[p];
  end

  assign passVal = OUT_W'(line[CTR]) <<< FRAC_W;

  always_comb begin
    if (strb.passThru)        nextOut = passVal;
    else if (strb.gainDouble) nextOut = accSum <<< 1;
    else                      nextOut = accSum;
  end

  always_ff @(posedge clk) begin
    if (rst)               dout <= '0;
    else if (strb.loadOut) dout <= nextOut;
  end

endmodule

// File: rtl/hb_filter.sv
module hb_filter
  import hb_filter_pkg::*;
#(
  parameter  int IN_W        = 12,
  parameter  int TAPS        = 39,
  parameter  int START_DELAY = 15,
  localparam int OUT_W       = IN_W + FRAC_W + 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              modeSel,
  input  logic                    halfGain,
  input  logic                    syncIn,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);

  hb_mode_e   modeReg;
  hb_strobe_t strb;

  hb_filter_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .modeSel  (modeSel),
    .halfGain (halfGain),
    .syncIn   (syncIn),
    .modeReg  (modeReg),
    .strb     (strb)
  );

  hb_filter_dp #(
    .IN_W        (IN_W),
    .TAPS        (TAPS),
    .START_DELAY (START_DELAY),
    .OUT_W       (OUT_W)
  ) u_dp (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .strb (strb),
    .dout (dout)
  );

endmodule

// File: rtl/hb_filter_chk.sv
module hb_filter_chk
  import hb_filter_pkg::*;
#(
  parameter int OUT_W = 31
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    syncIn,
  input hb_mode_e                modeReg,
  input hb_strobe_t              strb,
  input logic signed [OUT_W-1:0] dout
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> dout == '0);

  // R5
  interp_alternate_chk: assert property (@(posedge clk) disable iff (rst)
    (modeReg == MODE_INTERP && strb.feedSample) |=> !strb.feedSample);

  // R8
  decim_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (modeReg == MODE_DECIM && !syncIn && !$stable(dout)) |=> $stable(dout));

  // R9
  nointerp_feed_chk: assert property (@(posedge clk) disable iff (rst)
    (modeReg != MODE_INTERP) |-> strb.feedSample);

  // R9
  nodecim_load_chk: assert property (@(posedge clk) disable iff (rst)
    (modeReg != MODE_DECIM) |-> strb.loadOut);

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(modeReg));

endmodule

bind hb_filter hb_filter_chk #(.OUT_W(OUT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .syncIn  (syncIn),
  .modeReg (modeReg),
  .strb    (strb),
  .dout    (dout)
);

// File: tb/hb_filter_test.sv
`timescale 1ns/1ps
module hb_filter_test;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [1:0]         modeSel = 2'b10;
  logic               halfGain = 1'b0;
  logic               syncIn = 1'b0;
  logic signed [11:0] din = '0;
  logic signed [30:0] dout;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  int     curMode;
  bit     curHalf;
  int     stimDin  [0:255];
  bit     stimSync [0:255];
  longint xf       [0:255];

  always #2 clk = ~clk;

  hb_filter uut (
    .clk(clk), .rst(rst), .modeSel(modeSel), .halfGain(halfGain),
    .syncIn(syncIn), .din(din), .dout(dout)
  );

  function automatic longint coefAt(input int j);
    int d = (j > 19) ? j - 19 : 19 - j;
    case (d)
      0: return 32768;   1: return 20754;  3: return -6600;
      5: return 3600;    7: return -2250;  9: return 1450;
      11: return -900;   13: return 540;   15: return -300;
      17: return 150;    19: return -60;
      default: return 0;
    endcase
  endfunction

  function automatic longint convAt(input int e);
    longint s = 0;
    for (int j = 0; j < 39; j++)
      if (e - 15 - j >= 0) s += coefAt(j) * xf[e-15-j];
    return s;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic applyReset(input int mode, input bit half);
    curMode = mode; curHalf = half;
    modeSel = 2'(mode); halfGain = half;
    rst = 1'b1; syncIn = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    check("R1", longint'(dout), 0);
    rst = 1'b0;
  endtask

  task automatic clearStim();
    for (int i = 0; i < 256; i++) begin stimDin[i] = 0; stimSync[i] = 1'b0; end
  endtask

  // Drives the stored stimulus and compares dout after every edge
  task automatic runStream(input string tag, input int n);
    longint held = 0;
    longint expV;
    bit nextFlag = 1'b0;
    for (int i = 0; i < 256; i++) xf[i] = 0;
    for (int e = 0; e < n; e++) begin
      bit upd;
      din = 12'(stimDin[e]);
      syncIn = stimSync[e];
      if (curMode == 0) xf[e] = (nextFlag && !stimSync[e]) ? longint'(stimDin[e]) : 0;
      else              xf[e] = stimDin[e];
      upd = stimSync[e] || !nextFlag;
      nextFlag = stimSync[e] || !nextFlag;
      @(posedge clk); @(negedge clk);
      if (curMode == 3) expV = (e >= 34) ? xf[e-34] * 65536 : 0;
      else begin
        expV = convAt(e);
        if (curMode == 0 && !curHalf) expV = expV * 2;
        if (curMode == 1 && !upd) expV = held;
      end
      held = expV;
      check(tag, longint'(dout), expV);
    end
  endtask

  task automatic testReset();
    applyReset(2, 0);
    clearStim();
    stimDin[0] = 1500;
    runStream("R2", 40);
    rst = 1'b1;
    @(negedge clk);
    check("R1", longint'(dout), 0);
    @(negedge clk);
    check("R1", longint'(dout), 0);
  endtask

  task automatic testEqualImpulse();
    applyReset(2, 0);
    clearStim();
    stimDin[4] = 1000;
    runStream("R2", 70);
    check("R2", xf[4], 1000);
  endtask

  task automatic testEqualStep();
    applyReset(2, 0);
    clearStim();
    for (int i = 2; i < 256; i++) stimDin[i] = -700;
    runStream("R3", 80);
    check("R3", longint'(dout), -700 * 65536);
  endtask

  task automatic testEqualSyncIgnored();
    applyReset(2, 0);
    clearStim();
    for (int i = 0; i < 256; i++) begin
      stimDin[i] = int'($urandom_range(0, 4095)) - 2048;
      stimSync[i] = $urandom_range(0, 1) == 1;
    end
    runStream("R9", 90);
  endtask

  task automatic testBypass();
    applyReset(3, 0);
    modeSel = 2'b00;
    halfGain = 1'b1;
    clearStim();
    for (int i = 0; i < 256; i++) begin
      stimDin[i] = int'($urandom_range(0, 4095)) - 2048;
      stimSync[i] = $urandom_range(0, 1) == 1;
    end
    runStream("R4 R9 R10", 90);
  endtask

  task automatic testInterp(input bit half, input bit squareSync);
    applyReset(0, half);
    clearStim();
    stimSync[0] = 1'b1;
    for (int i = 1; i < 256; i++) begin
      stimDin[i] = (i % 2 == 1) ? ((i == 5) ? 1800 : 900) : -1500;
      if (squareSync) stimSync[i] = (i % 2 == 0);
    end
    runStream(half ? "R5 R7" : "R5 R6", 100);
    check(half ? "R7" : "R6", longint'(dout), half ? 900 * 32768 : 900 * 65536);
    @(posedge clk); @(negedge clk);
    check(half ? "R7" : "R6", longint'(dout), half ? 900 * 32768 : 900 * 65536);
  endtask

  task automatic testDecim(input bit squareSync);
    longint prev;
    applyReset(1, 0);
    clearStim();
    stimSync[3] = 1'b1;
    for (int i = 4; i < 256; i++) begin
      stimDin[i] = (i < 30) ? (i * 37 - 600) : 1100;
      if (squareSync) stimSync[i] = (i % 2 == 1);
    end
    runStream("R8 R11", 96);
    check("R11", longint'(dout), 1100 * 65536);
    din = 12'sd0;
    syncIn = squareSync;
    @(posedge clk); @(negedge clk);
    prev = longint'(dout);
    syncIn = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8", longint'(dout), prev);
  endtask

  task automatic testExtremes();
    applyReset(2, 0);
    clearStim();
    for (int i = 0; i < 256; i++) stimDin[i] = (i % 2 == 0) ? 2047 : -2048;
    runStream("R2", 80);
    applyReset(0, 0);
    clearStim();
    stimSync[0] = 1'b1;
    for (int i = 1; i < 256; i++) stimDin[i] = ((i / 2) % 2 == 0) ? 2047 : -2048;
    runStream("R6", 80);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testEqualImpulse();
    testEqualStep();
    testEqualSyncIgnored();
    testBypass();
    testInterp(1'b0, 1'b0);
    testInterp(1'b1, 1'b1);
    testDecim(1'b0);
    testDecim(1'b1);
    testExtremes();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule